// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This block sits on the host side of a management bus and turns one wide register request into the series of 16-bit bus transactions that reach a register hidden behind a paged access window. A request names a page, an offset inside that page, a width code, a direction and up to 64 bits of write data. The sequencer selects the page, stages write data, issues a command word and polls that command word until the target reports completion. For a read it then collects the result words.

The block remembers the page it last selected and skips the page-select transaction when the next request targets the same page. Completion polling has a fixed number of attempts and a programmable idle gap between attempts. A failed write transaction, or polling that never completes, ends the request with an error. The bus side is a simple request/done transaction port: one transaction is in flight while `bus_req` is high and it completes in the cycle `bus_done` is sampled high.

Top module: `pgwin_seq`

## Requirements
- R1: The page-select transaction is issued only when the requested page differs from the remembered page. The remembered page takes the new value only after a page-select write completes without `bus_err`.
- R2: After reset the remembered page is 0xFF, so the first request to any other page (page 0 included) issues a page select.
- R3: The page select is a write to register 0x10 with value {page, 8'h01}.
- R4: The command is a write to register 0x11 with value {offset, 6'b0, op}. op is 2'b01 for a write and 2'b10 for a read. Every transaction addresses only 0x10, 0x11 or 0x18..0x1B.
- R5: Completion is polled by reading register 0x11 until bits [1:0] read as zero, with at most POLL_TRIES reads (default 5). If all of them read busy, the request ends with `err`. `bus_req` stays low for at least POLL_GAP cycles between two polls.
- R6: A write request first writes its data words to 0x18, 0x19, ... in ascending order, least significant word first, and only then issues the page select and the command. Width code 0 = 8 bit and 1 = 16 bit give 1 word, 2 = 32 bit gives 2, 3 = 48 bit gives 3, and 4..7 = 64 bit give 4. An 8-bit write sends {8'h00, data[7:0]}.
- R7: After completion a read request reads the same number of words from 0x18 upward and assembles them least significant word first into `rdata`. Bits above the requested width are zero, so an 8-bit read keeps only the low byte.
- R8: A write transaction that completes with `bus_err` aborts the request. `done` and `err` rise in the next cycle and no further transaction is issued. `bus_err` on read transactions is ignored.
- R9: `busy` is low only when idle. A request is taken when `req_valid` is high and `busy` is low. `req_valid` while `busy` is high is ignored.
- R10: Every transaction carries the fixed device address PHY_ADDR (default 5'h1E) on `bus_phy`.
- R11: `done` is a one-cycle pulse that ends each request. `err` is high only together with `done`. `rdata` is updated only by a read that succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Width code (0:8, 1:16, 2:32, 3:48, 4..7:64 bits) |
| req_page | input | 8 | Target page |
| req_offset | input | 8 | Register offset within the page |
| req_wdata | input | 64 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request failed (valid with done) |
| rdata | output | 64 | Read result, zero above the width |
| bus_req | output | 1 | Transaction active |
| bus_wr | output | 1 | Transaction is a write |
| bus_phy | output | 5 | Device address of transaction |
| bus_reg | output | 5 | Register address of transaction |
| bus_wdata | output | 16 | Write word |
| bus_rdata | input | 16 | Read word, valid with bus_done |
| bus_done | input | 1 | Transaction completes this cycle |
| bus_err | input | 1 | Transaction failed (valid with bus_done) |

## Verification
The assertions assume that the bus responder follows the handshake: it raises `bus_done` only while `bus_req` is high, and it qualifies `bus_err` and `bus_rdata` with `bus_done`. Under that assumption the block's outputs stay stable while a transaction is pending. The bench's responder models the paged window. It answers only active transactions, applies a chosen latency of zero to two cycles, and raises errors or busy poll results only at counts set per request. The bench issues requests only while `busy` is low, except for the deliberate overlap test.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;

  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 4;
  localparam int DATA_W    = WORD_W * MAX_WORDS;
  localparam int PAGE_W    = 8;
  localparam int OFS_W     = 8;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int CNT_W     = IDX_W + 1;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_WDATA, S_PAGE, S_CMD, S_POLL, S_GAP, S_RDATA, S_FIN
  } seq_state_t;

  // number of 16-bit words moved for a width code
  function automatic logic [CNT_W-1:0] word_count(input logic [2:0] sz);
    case (sz)
      3'd0, 3'd1: word_count = CNT_W'(1);
      3'd2:       word_count = CNT_W'(2);
      3'd3:       word_count = CNT_W'(3);
      default:    word_count = CNT_W'(MAX_WORDS);
    endcase
  endfunction

  // valid result bits for a width code
  function automatic logic [DATA_W-1:0] width_mask(input logic [2:0] sz);
    case (sz)
      3'd0:    width_mask = DATA_W'(8'hFF);
      3'd1:    width_mask = {{(DATA_W-16){1'b0}}, {16{1'b1}}};
      3'd2:    width_mask = {{(DATA_W-32){1'b0}}, {32{1'b1}}};
      3'd3:    width_mask = {{(DATA_W-48){1'b0}}, {48{1'b1}}};
      default: width_mask = {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] page_word(input logic [PAGE_W-1:0] pg);
    page_word = {pg, 8'h01};
  endfunction

  function automatic logic [WORD_W-1:0] cmd_word(input logic [OFS_W-1:0] ofs,
                                                 input logic [1:0] op);
    cmd_word = {ofs, 6'b0, op};
  endfunction

endpackage

// File: rtl/pgwin_pagecache.sv
module pgwin_pagecache
  import pgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [PAGE_W-1:0] probe_page,
  output logic              hit,
  output logic [PAGE_W-1:0] cur_page
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cur_page <= '1;
    else if (upd) cur_page <= upd_page;
  end

  assign hit = (probe_page == cur_page);

  assert_cache_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cur_page == $past(upd_page)));

endmodule

// File: rtl/pgwin_pace.sv
module pgwin_pace #(
  parameter int TRIES = 5,
  parameter int GAP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic poll_busy,
  input  logic poll_req,
  output logic last_try,
  output logic gap_open
);

  localparam int CW = $clog2(TRIES + 1);
  localparam int GW = (GAP > 0) ? $clog2(GAP + 1) : 1;

  logic [CW-1:0] tries_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q <= '0;
      gap_q   <= '0;
    end else begin
      if (arm)            tries_q <= '0;
      else if (poll_busy) tries_q <= tries_q + 1'b1;
      if (poll_busy)        gap_q <= GW'(GAP);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign last_try = (tries_q == CW'(TRIES - 1));
  assign gap_open = (gap_q == '0);

  assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tries_q <= CW'(TRIES));

  assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != '0) |-> !poll_req);

endmodule

// File: rtl/pgwin_pack.sv
module pgwin_pack
  import pgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [2:0]        size,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wsrc,
  output logic [WORD_W-1:0] word_out,
  input  logic              cap,
  input  logic [WORD_W-1:0] cap_word,
  output logic [DATA_W-1:0] assembled
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] merged;
  logic [WORD_W-1:0] sel;

  assign sel      = wsrc[widx*WORD_W +: WORD_W];
  assign word_out = (size == 3'd0) ? {8'h00, sel[7:0]} : sel;

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    assign merged[g*WORD_W +: WORD_W] =
      (cap && (widx == IDX_W'(g))) ? cap_word : acc_q[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else if (cap)   acc_q <= merged;
  end

  assign assembled = merged & width_mask(size);

endmodule

// File: rtl/pgwin_seq.sv
module pgwin_seq
  import pgwin_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR   = 5'h1E,
  parameter logic [4:0] REG_PAGE   = 5'h10,
  parameter logic [4:0] REG_CMD    = 5'h11,
  parameter logic [4:0] REG_DATA   = 5'h18,
  parameter int         POLL_TRIES = 5,
  parameter int         POLL_GAP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_size,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [4:0]        bus_phy,
  output logic [4:0]        bus_reg,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_done,
  input  logic              bus_err
);

  seq_state_t        st;
  logic [IDX_W-1:0]  idx;
  logic              l_write;
  logic [2:0]        l_size;
  logic [PAGE_W-1:0] l_page;
  logic [OFS_W-1:0]  l_ofs;
  logic [DATA_W-1:0] l_wdata;
  logic              need_pg;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  // named events
  logic              accept;
  logic              xfer;
  logic              last_word;
  logic              poll_busy;
  logic              poll_ok;
  logic              page_ok;
  logic              cmd_ok;
  logic              poll_req;
  logic              cache_hit;
  logic [PAGE_W-1:0] cache_page;
  logic              last_try;
  logic              gap_open;
  logic [WORD_W-1:0] data_word;
  logic [DATA_W-1:0] assembled;

  assign accept    = (st == S_IDLE) && req_valid;
  assign xfer      = bus_req && bus_done;
  assign last_word = ((CNT_W'(idx) + 1'b1) == word_count(l_size));
  assign poll_busy = xfer && (st == S_POLL) && (bus_rdata[1:0] != 2'b00);
  assign poll_ok   = xfer && (st == S_POLL) && (bus_rdata[1:0] == 2'b00);
  assign page_ok   = xfer && (st == S_PAGE) && !bus_err;
  assign cmd_ok    = xfer && (st == S_CMD) && !bus_err;
  assign poll_req  = bus_req && !bus_wr && (bus_reg == REG_CMD);

  pgwin_pagecache u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (page_ok),
    .upd_page   (l_page),
    .probe_page (req_page),
    .hit        (cache_hit),
    .cur_page   (cache_page)
  );

  pgwin_pace #(.TRIES(POLL_TRIES), .GAP(POLL_GAP)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (cmd_ok),
    .poll_busy (poll_busy),
    .poll_req  (poll_req),
    .last_try  (last_try),
    .gap_open  (gap_open)
  );

  pgwin_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .size      (l_size),
    .widx      (idx),
    .wsrc      (l_wdata),
    .word_out  (data_word),
    .cap       (xfer && (st == S_RDATA)),
    .cap_word  (bus_rdata),
    .assembled (assembled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      l_write <= 1'b0;
      l_size  <= '0;
      l_page  <= '0;
      l_ofs   <= '0;
      l_wdata <= '0;
      need_pg <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          l_write <= req_write;
          l_size  <= req_size;
          l_page  <= req_page;
          l_ofs   <= req_offset;
          l_wdata <= req_wdata;
          need_pg <= !cache_hit;
          idx     <= '0;
          err_q   <= 1'b0;
          if (req_write)       st <= S_WDATA;
          else if (!cache_hit) st <= S_PAGE;
          else                 st <= S_CMD;
        end
        S_WDATA: if (xfer) begin
          if (bus_err) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else if (last_word) begin
            idx <= '0;
            st  <= need_pg ? S_PAGE : S_CMD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_PAGE: if (xfer) begin
          if (bus_err) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            st <= S_CMD;
          end
        end
        S_CMD: if (xfer) begin
          if (bus_err) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            st <= S_POLL;
          end
        end
        S_POLL: if (xfer) begin
          if (poll_ok) begin
            idx <= '0;
            st  <= l_write ? S_FIN : S_RDATA;
          end else if (last_try) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP: if (gap_open) st <= S_POLL;
        S_RDATA: if (xfer) begin
          if (last_word) begin
            rdata_q <= assembled;
            st      <= S_FIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req   = 1'b0;
    bus_wr    = 1'b0;
    bus_reg   = REG_CMD;
    bus_wdata = '0;
    case (st)
      S_WDATA: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_reg   = REG_DATA + 5'(idx);
        bus_wdata = data_word;
      end
      S_PAGE: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_reg   = REG_PAGE;
        bus_wdata = page_word(l_page);
      end
      S_CMD: begin
        bus_req   = 1'b1;
        bus_wr    = 1'b1;
        bus_reg   = REG_CMD;
        bus_wdata = cmd_word(l_ofs, l_write ? OP_WRITE : OP_READ);
      end
      S_POLL: begin
        bus_req = 1'b1;
        bus_reg = REG_CMD;
      end
      S_RDATA: begin
        bus_req = 1'b1;
        bus_reg = REG_DATA + 5'(idx);
      end
      default: ;
    endcase
  end

  assign bus_phy = PHY_ADDR;
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign err     = (st == S_FIN) && err_q;
  assign rdata   = rdata_q;

  assert_bus_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_reg) && $stable(bus_wdata) && $stable(bus_wr)));

  assert_write_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_err && bus_wr) |=> (done && err && !bus_req));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  assert_page_skip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAGE) |-> (cache_page != l_page));

endmodule

// File: tb/sim_pgwin_seq.sv
module sim_pgwin_seq;

  localparam int CLK_PERIOD = 10;
  localparam int TRIES      = 5;
  localparam int GAP        = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_size;
  logic [7:0]  req_page, req_offset;
  logic [63:0] req_wdata;
  logic        busy, done, err;
  logic [63:0] rdata;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_phy, bus_reg;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_done, bus_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwin_seq #(.POLL_TRIES(TRIES), .POLL_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_page(req_page), .req_offset(req_offset),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_phy(bus_phy), .bus_reg(bus_reg),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .bus_err(bus_err)
  );

  int n_run = 0, n_fail = 0;

  // responder / window model state
  int lat = 0, wcnt = 0, busy_cfg = 0, busy_left = 0, inj_at = 0, wr_seen = 0;
  int n_pg, n_dw, n_cmd, n_poll, n_dr, n_other = 0, bad_phy = 0, order_bad = 0;
  int idle_cnt = 0, min_gap = 1000;
  bit seen_ctrl, prev_poll = 0;
  logic [15:0] s_page = 16'h0, s_cmd = 16'h0, last_cmd, last_pg;
  logic [15:0] s_d [4];
  logic [63:0] mem [logic [15:0]];
  logic [7:0]  exp_cache = 8'hFF;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [15:0] k);
    return {k ^ 16'h5A5A, k + 16'h0101, ~k, k};
  endfunction

  function automatic int nwords(input logic [2:0] sz);
    if (sz <= 3'd1) return 1;
    if (sz >= 3'd4) return 4;
    return int'(sz);
  endfunction

  function automatic logic [63:0] msk(input logic [2:0] sz);
    int nb;
    nb = (sz == 3'd0) ? 8 : 16 * nwords(sz);
    return (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
  endfunction

  task automatic serve();
    logic [15:0] w;
    logic [15:0] key;
    logic [63:0] v;
    int di;
    w  = bus_wdata;
    di = int'(bus_reg) - 'h18;
    if (bus_phy != 5'h1E) bad_phy++;
    if (bus_wr) begin
      wr_seen++;
      prev_poll = 0;
      if (inj_at == wr_seen) bus_err = 1'b1;
      else if (bus_reg == 5'h10) begin
        n_pg++; last_pg = w; s_page = w; seen_ctrl = 1;
      end else if (bus_reg == 5'h11) begin
        n_cmd++; last_cmd = w; s_cmd = w; seen_ctrl = 1;
        key = {s_page[15:8], w[15:8]};
        if (w[1:0] == 2'b01) mem[key] = {s_d[3], s_d[2], s_d[1], s_d[0]};
        else if (w[1:0] == 2'b10) begin
          v = mem.exists(key) ? mem[key] : pat(key);
          s_d[0] = v[15:0]; s_d[1] = v[31:16]; s_d[2] = v[47:32]; s_d[3] = v[63:48];
        end
        busy_left = busy_cfg;
      end else if (di >= 0 && di < 4) begin
        n_dw++;
        if (seen_ctrl) order_bad++;
        s_d[di] = w;
      end else n_other++;
    end else begin
      if (bus_reg == 5'h11) begin
        if (prev_poll && idle_cnt < min_gap) min_gap = idle_cnt;
        prev_poll = 1;
        n_poll++;
        bus_rdata = (busy_left > 0) ? s_cmd : (s_cmd & 16'hFFFC);
        if (busy_left > 0) busy_left--;
      end else begin
        prev_poll = 0;
        if (di >= 0 && di < 4) begin
          n_dr++; bus_rdata = s_d[di];
        end else n_other++;
      end
    end
    idle_cnt = 0;
  endtask

  initial begin
    bus_done = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    for (int i = 0; i < 4; i++) s_d[i] = 16'h0;
    forever begin
      @(negedge clk);
      bus_done = 1'b0; bus_err = 1'b0;
      if (!bus_req) idle_cnt++;
      else if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        serve();
        bus_done = 1'b1;
      end
    end
  end

  // wd: write data for writes, expected read result for reads
  task automatic do_req(input logic [7:0] pg, input logic [7:0] ofs,
                        input logic [2:0] sz, input bit wr, input logic [63:0] wd,
                        input int bz, input int inj, input bit spam,
                        input string tag);
    int nw, pgn, tot, e_dw, e_pg, e_cmd, e_poll, e_dr, cmd_before;
    bit fail, e_err, got_err;
    logic [63:0] got_rd;
    nw = nwords(sz);
    pgn = (pg != exp_cache) ? 1 : 0;
    tot = (wr ? nw : 0) + pgn + 1;
    fail = (inj >= 1) && (inj <= tot);
    e_dw = 0; e_pg = 0; e_cmd = 0;
    for (int i = 1; i <= tot; i++) begin
      if (fail && i >= inj) break;
      if (wr && i <= nw) e_dw++;
      else if (pgn == 1 && i == (wr ? nw : 0) + 1) e_pg++;
      else e_cmd++;
    end
    e_poll = fail ? 0 : ((bz + 1 > TRIES) ? TRIES : bz + 1);
    e_err  = fail || (bz >= TRIES);
    e_dr   = (!wr && !e_err) ? nw : 0;
    if (e_pg == 1) exp_cache = pg;

    busy_cfg = bz; inj_at = inj; wr_seen = 0; seen_ctrl = 0;
    n_pg = 0; n_dw = 0; n_cmd = 0; n_poll = 0; n_dr = 0; last_cmd = 0; last_pg = 0;

    @(negedge clk);
    req_page = pg; req_offset = ofs; req_size = sz; req_write = wr;
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (spam) begin
      req_page = pg ^ 8'h11; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    got_err = err; got_rd = rdata;

    chk(n_pg == e_pg, $sformatf("R1 page writes %s", tag), 64'(n_pg), 64'(e_pg));
    chk(n_dw == e_dw, $sformatf("R6 data writes %s", tag), 64'(n_dw), 64'(e_dw));
    chk(n_cmd == e_cmd, $sformatf("R4 command writes %s", tag), 64'(n_cmd), 64'(e_cmd));
    chk(n_poll == e_poll, $sformatf("R5 polls %s", tag), 64'(n_poll), 64'(e_poll));
    chk(n_dr == e_dr, $sformatf("R7 data reads %s", tag), 64'(n_dr), 64'(e_dr));
    chk(got_err == e_err, $sformatf("R5/R8 err flag %s", tag), 64'(got_err), 64'(e_err));
    if (e_cmd == 1)
      chk(last_cmd == {ofs, 6'b0, wr ? 2'b01 : 2'b10},
          $sformatf("R4 command value %s", tag), 64'(last_cmd),
          64'({ofs, 6'b0, wr ? 2'b01 : 2'b10}));
    if (e_pg == 1)
      chk(last_pg == {pg, 8'h01}, $sformatf("R3 page value %s", tag),
          64'(last_pg), 64'({pg, 8'h01}));
    if (!wr && !e_err)
      chk(got_rd == wd, $sformatf("R7 read data %s", tag), got_rd, wd);
    @(negedge clk);
    chk(!done && !err, $sformatf("R11 done pulse %s", tag), 64'({done, err}), 64'd0);
    if (spam) begin
      cmd_before = n_cmd;
      repeat (6) @(negedge clk);
      chk(n_cmd == cmd_before && !busy, "R9 request while busy ignored",
          64'(n_cmd), 64'(cmd_before));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] wd;
    logic [7:0]  pg, ofs;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = '0;
    req_page = '0; req_offset = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_req, "R9 reset idle", 64'({busy, bus_req}), 64'd0);
    chk(!done && !err, "R11 reset no done", 64'({done, err}), 64'd0);

    // R2: cached page is 0xFF after reset, page 0 needs a select
    do_req(8'h00, 8'h05, 3'd1, 1'b0, pat(16'h0005) & msk(3'd1), 0, 0, 0, "R2 first");

    // round trips over all width codes, two pages, two offsets
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 5; s++)
        for (int o = 0; o < 2; o++) begin
          pg  = p ? 8'h07 : 8'h00;
          ofs = o ? 8'hF0 + 8'(s) : 8'(s);
          wd  = 64'hF0E1_D2C3_B4A5_9687 ^ {8{ofs}} ^ (64'(pg) << (s * 8));
          lat = (s + o) % 3;
          do_req(pg, ofs, 3'(s), 1'b1, wd, 0, 0, 0, "sweep write");
          do_req(pg, ofs, 3'(s), 1'b0, wd & msk(3'(s)), 0, 0, 0, "sweep read");
        end

    // R7: untouched locations, byte and 48-bit reads
    lat = 1;
    do_req(8'h03, 8'h40, 3'd0, 1'b0, pat(16'h0340) & msk(3'd0), 0, 0, 0, "R7 byte");
    do_req(8'h03, 8'h41, 3'd3, 1'b0, pat(16'h0341) & msk(3'd3), 0, 0, 0, "R7 48bit");

    // R6: width code 7 moves four words
    do_req(8'h00, 8'h33, 3'd7, 1'b1, 64'h1122_3344_5566_7788, 0, 0, 0, "R6 code7 write");
    do_req(8'h00, 8'h33, 3'd4, 1'b0, 64'h1122_3344_5566_7788, 0, 0, 0, "R6 code7 read");

    // R5: busy polls 0..5
    for (int b = 0; b <= 5; b++) begin
      lat = b % 2;
      ofs = 8'h20 + 8'(b);
      do_req(8'h02, ofs, 3'd2, 1'b0, pat({8'h02, ofs}) & msk(3'd2), b, 0, 0, "R5 poll");
    end
    chk(min_gap >= GAP && min_gap < 1000, "R5 poll gap", 64'(min_gap), 64'(GAP));

    // R8 and R1: write errors
    lat = 0;
    do_req(8'h05, 8'h01, 3'd2, 1'b1, 64'hAAAA_BBBB, 0, 1, 0, "R8 data fail");
    do_req(8'h05, 8'h01, 3'd2, 1'b1, 64'hAAAA_BBBB, 0, 3, 0, "R8 page fail");
    do_req(8'h05, 8'h01, 3'd2, 1'b0, pat(16'h0501) & msk(3'd2), 0, 0, 0, "R1 reselect");
    do_req(8'h06, 8'h02, 3'd1, 1'b1, 64'h0000_CAFE, 0, 3, 0, "R8 cmd fail");
    do_req(8'h06, 8'h02, 3'd1, 1'b0, pat(16'h0602) & msk(3'd1), 0, 0, 0, "R1 kept");
    do_req(8'h09, 8'h03, 3'd0, 1'b0, 64'h0, 0, 1, 0, "R8 read page fail");

    // R9: requests during busy are ignored
    lat = 1;
    do_req(8'h00, 8'h55, 3'd3, 1'b0, pat(16'h0055) & msk(3'd3), 0, 0, 1, "R9 overlap");

    chk(bad_phy == 0, "R10 device address", 64'(bad_phy), 64'd0);
    chk(order_bad == 0, "R6 data before control", 64'(order_bad), 64'd0);
    chk(n_other == 0, "R4 register addresses", 64'(n_other), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule